// File: doc/BRIEF.md
# Automatic Holdover Controller for a Phase-Locked Loop

This controller decides when a phase-locked loop should coast on its oscillator because the reference has gone away. It follows the loop's digital lock flag and the level on the lock-detect pin. When the lock flag drops and the pin showed a locked loop, it drives the charge pump to high impedance, so the oscillator control voltage, and with it the frequency, stays where it was. The loop dividers are not touched and keep counting.

The pump stays tri-stated until a reference edge reaches the phase/frequency detector. That edge releases the pump so the loop can settle again. The controller then stays disarmed until the lock flag is reported high once more. This keeps a loop that is still reacquiring from falling straight back into holdover. The lock flag only rises after a programmable run of 5 to 255 in-window comparisons, so re-arming waits for a settled loop. A configuration bit can disconnect the pin comparator, and the pin then counts as permanently high. Clearing the loop enable drops everything back to idle and frees the pump.

Top module: `pll_holdover_ctrl`

## Requirements
- R1: While `pllEnable` is 0, the block is idle. A fall of `lockFlag` has no effect, and both outputs stay 0.
- R2: In the armed state, a 1-to-0 change of `lockFlag` (1 in the previous cycle, 0 now) enters holdover at the next clock edge if the effective pin level registered in the previous cycle was 1.
- R3: With `ldCompEnable` = 1, a lock-flag fall does not enter holdover when `ldPin` was 0 in the cycle before the fall. The pin level in the cycle of the fall itself is not used.
- R4: With `ldCompEnable` = 0, the pin level counts as 1, and a lock-flag fall always enters holdover from the armed state.
- R5: In holdover, `cpTristate` stays 1 until `refEdge` is 1. A return of `lockFlag` alone does not release it.
- R6: A cycle with `refEdge` = 1 in holdover clears `cpTristate` at that clock edge.
- R7: After a release, a lock-flag fall cannot re-enter holdover until `lockFlag` has been seen at 1 again. A `lockFlag` of 1 in the release cycle itself does not count.
- R8: Clearing `pllEnable` in any state clears `cpTristate` and `holdoverActive` at the next clock edge.
- R9: `holdoverActive` equals `cpTristate` in every cycle: it is 1 from entry until release.
- R10: Reset (active-low `rstN`, asynchronous) forces idle with both outputs at 0, including in the middle of holdover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pllEnable | input | 1 | Loop enable; 0 forces idle |
| lockFlag | input | 1 | Digital lock-detect flag |
| ldPin | input | 1 | Level seen on the lock-detect pin |
| ldCompEnable | input | 1 | 1 = use the pin level, 0 = treat the pin as high |
| refEdge | input | 1 | One-cycle strobe for a reference edge at the phase detector |
| cpTristate | output | 1 | 1 = charge pump held in high impedance |
| holdoverActive | output | 1 | Holdover status |

## Verification
The block has no numeric parameters, so the bench builds the one default configuration. The table covers every state-to-state path: entry with the pin high or with the comparator off, refusal when the pin was low one cycle earlier, a lock return that does not release, release on a reference edge, a fall inside the re-lock window, and disable from holdover. Directed steps then check reset in the middle of holdover and a reference edge while idle.

// File: rtl/pll_holdover_pkg.sv
package pll_holdover_pkg;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_ARMED  = 2'd1,
    ST_HOLD   = 2'd2,
    ST_RELOCK = 2'd3
  } hoState_e;

  typedef struct packed {
    logic setTri;
    logic clrTri;
  } hoStrobe_t;

endpackage

// File: rtl/pll_holdover_dp.sv
module pll_holdover_dp
  import pll_holdover_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      lockFlag,
  input  logic      ldPin,
  input  logic      ldCompEnable,
  input  hoStrobe_t strobe,
  output logic      lockFall,
  output logic      ldEff,
  output logic      cpTristate
);

  logic lockQ;
  logic ldQ;

  // History registers: previous lock flag and previous pin level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ <= 1'b0;
      ldQ   <= 1'b0;
    end else begin
      lockQ <= lockFlag;
      ldQ   <= ldPin;
    end
  end

  assign lockFall = lockQ & ~lockFlag;
  // The comparator bit masks the pin level seen one cycle earlier
  assign ldEff    = ~ldCompEnable | ldQ;

  // Charge-pump tri-state flop; a clear wins over a set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cpTristate <= 1'b0;
    else if (strobe.clrTri) cpTristate <= 1'b0;
    else if (strobe.setTri) cpTristate <= 1'b1;
  end

  // R6: the tri-state is only set on a commanded entry
  p_set_only_on_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpTristate) |-> $past(strobe.setTri));

endmodule

// File: rtl/pll_holdover_fsm.sv
module pll_holdover_fsm
  import pll_holdover_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pllEnable,
  input  logic      lockFlag,
  input  logic      refEdge,
  input  logic      lockFall,
  input  logic      ldEff,
  output hoStrobe_t strobe,
  output logic      holdActive
);

  hoState_e state;
  hoState_e stateNext;

  always_comb begin
    stateNext     = state;
    strobe.setTri = 1'b0;
    strobe.clrTri = 1'b0;
    if (!pllEnable) begin
      stateNext     = ST_OFF;
      strobe.clrTri = 1'b1;
    end else begin
      unique case (state)
        ST_OFF:    stateNext = ST_ARMED;
        ST_ARMED: begin
          if (lockFall && ldEff) begin
            stateNext     = ST_HOLD;
            strobe.setTri = 1'b1;
          end
        end
        ST_HOLD: begin
          if (refEdge) begin
            stateNext     = ST_RELOCK;
            strobe.clrTri = 1'b1;
          end
        end
        ST_RELOCK: begin
          if (lockFlag) stateNext = ST_ARMED;
        end
        default:   stateNext = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  assign holdActive = (state == ST_HOLD);

  // R2: holdover starts only after a lock fall with the pin level high
  p_entry_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdActive) |-> $past(lockFall && ldEff && pllEnable));

  // R6: holdover ends only on a reference edge or a disable
  p_release_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdActive) |-> ($past(refEdge) || !$past(pllEnable)));

  // R8: a disable always leaves holdover at the next edge
  p_disable_exits_r8: assert property (@(posedge clk) disable iff (!rstN)
    !pllEnable |=> !holdActive);

  // R7: no re-entry while waiting for lock to return
  p_no_retrigger_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RELOCK && !lockFlag) |=> !holdActive);

endmodule

// File: rtl/pll_holdover_ctrl.sv
module pll_holdover_ctrl
  import pll_holdover_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic pllEnable,
  input  logic lockFlag,
  input  logic ldPin,
  input  logic ldCompEnable,
  input  logic refEdge,
  output logic cpTristate,
  output logic holdoverActive
);

  hoStrobe_t strobe;
  logic      lockFall;
  logic      ldEff;

  pll_holdover_fsm fsm_i (
    .clk       (clk),
    .rstN      (rstN),
    .pllEnable (pllEnable),
    .lockFlag  (lockFlag),
    .refEdge   (refEdge),
    .lockFall  (lockFall),
    .ldEff     (ldEff),
    .strobe    (strobe),
    .holdActive(holdoverActive)
  );

  pll_holdover_dp dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .lockFlag    (lockFlag),
    .ldPin       (ldPin),
    .ldCompEnable(ldCompEnable),
    .strobe      (strobe),
    .lockFall    (lockFall),
    .ldEff       (ldEff),
    .cpTristate  (cpTristate)
  );

  // R9: the status from the state register matches the pump flop
  p_status_match_r9: assert property (@(posedge clk) disable iff (!rstN)
    holdoverActive == cpTristate);

endmodule

// File: tb/pll_holdover_ctrl_tb_top.sv
module pll_holdover_ctrl_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pllEnable = 1'b0;
  logic lockFlag = 1'b0;
  logic ldPin = 1'b0;
  logic ldCompEnable = 1'b1;
  logic refEdge = 1'b0;
  logic cpTristate;
  logic holdoverActive;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pll_holdover_ctrl dut_i (
    .clk(clk), .rstN(rstN), .pllEnable(pllEnable), .lockFlag(lockFlag),
    .ldPin(ldPin), .ldCompEnable(ldCompEnable), .refEdge(refEdge),
    .cpTristate(cpTristate), .holdoverActive(holdoverActive)
  );

  // Fields: {pllEnable, lockFlag, ldPin, ldCompEnable, refEdge, expectHold}
  localparam int NVEC = 20;
  localparam logic [5:0] VEC [NVEC] = '{
    6'b111100, // 0  enable, go armed                 R1
    6'b111100, // 1  locked
    6'b101101, // 2  fall, pin was high -> hold       R2
    6'b100101, // 3  no ref edge -> stay              R5
    6'b110101, // 4  lock back, no ref -> stay        R5
    6'b100110, // 5  ref edge -> release              R6
    6'b100100, // 6  wait for lock
    6'b110100, // 7  lock seen -> armed
    6'b101100, // 8  fall, pin low one cycle earlier  R3
    6'b110100, // 9  locked again, pin low
    6'b100001, // 10 fall, comparator off -> hold     R4
    6'b111010, // 11 ref edge with lock high -> release R7
    6'b101100, // 12 fall while re-locking -> ignored R7
    6'b111100, // 13 lock seen -> armed
    6'b101101, // 14 fall, pin high -> hold           R2
    6'b001100, // 15 disable -> release               R8
    6'b011100, // 16 disabled
    6'b001100, // 17 fall while disabled              R1
    6'b101100, // 18 re-enabled, armed
    6'b101110  // 19 ref edge while armed ignored     R6
  };

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic checkBoth(input string req, input logic exp);
    check(req, cpTristate, exp);
    check({req, "/R9"}, holdoverActive, exp);
  endtask

  task automatic step(input logic [4:0] in);
    @(negedge clk);
    {pllEnable, lockFlag, ldPin, ldCompEnable, refEdge} = in;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    #5;
    checkBoth("R10 reset", 1'b0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][5:1]);
      checkBoth($sformatf("vector %0d", i), VEC[i][0]);
    end

    // R10: reset in the middle of holdover
    step(5'b11110);
    step(5'b11110);
    step(5'b10110);
    checkBoth("R2 enter before reset", 1'b1);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    checkBoth("R10 async reset in hold", 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    step(5'b10110);
    checkBoth("R10 idle after reset", 1'b0);

    // R1: reference edge and lock activity while disabled
    step(5'b01111);
    step(5'b00111);
    checkBoth("R1 disabled fall", 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule